// File: doc/BRIEF.md
# Counter-Tap Interval Interrupt Generator

This block runs a 16-bit up-counter and treats four of its bits as interval taps. Channel n watches counter bit 10+n. Each time a tap goes from 0 to 1 while that channel is enabled, the channel's status flag is set. The flag stays set until software clears it. While the flag and its enable are both 1, the channel drives an interrupt request toward the interrupt controller.

With a count tick on every cycle, the lowest channel fires every 2048 ticks. Each higher channel fires half as often as the one below it. This gives software four fixed periodic interrupts from one free-running counter, with no period register to program.

Software uses a single-cycle register port. Through it, software can read and load the counter, set the enables, read the flags and clear them. A flag is cleared by reading it as 1 and then writing 0 to it. An edge that arrives in the same cycle as the clear wins, so no interval event is lost.

Top module: `itv_tap_irq`

## Requirements
- R1: After synchronous reset the counter is 0, all enable bits are 0, all flags are 0 and every irq output is 0.
- R2: The counter adds one on each clock where `tick` is 1 and holds otherwise. It wraps from 0xFFFF to 0. A counter write loads `reg_wdata` and takes priority over the tick.
- R3: Interval channel n (n = 0..3) watches counter bit 10+n: channel 0 uses bit 10 and channel 3 uses bit 13.
- R4: A channel's tap event is that tap bit being 0 in one cycle and 1 in the next. This includes a change made by a counter write. The flag is visible one clock after the counter shows the new tap value. Falling transitions and steady levels cause no event.
- R5: A tap event on a channel whose enable bit is 0 leaves that channel's flag unchanged.
- R6: Flags are sticky. Status register bit n reads flag n, and once set it stays set until cleared as in R7.
- R7: Writing 0 to status bit n clears flag n only if a status read, strobed with `reg_rd`, returned that bit as 1 after the previous status write. Writing 1 to a status bit has no effect, and so does writing 0 to a bit that was not read as 1.
- R8: When a clear and a tap event on the same channel fall in the same cycle, the flag stays set.
- R9: `irq[n]` is flag n AND enable n. Clearing the enable removes the request but keeps the flag.
- R10: With `tick` held at 1, channel n first sets its flag when the counter reaches 2^(10+n). It sets again every 2^(11+n) ticks, which is 32, 16, 8 and 4 times per 65536 ticks for channels 0 to 3.
- R11: Register select values are 0 = counter (16 bits), 1 = enable (bit n = channel n), 2 = status (bit n = channel n), 3 = unused. Unused bits and select 3 read 0, and writes to select 3 are ignored. `reg_rdata` follows `reg_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count advance strobe |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; arms status clears |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq | output | 4 | Per-channel interval interrupt requests |

## Verification
The bench sweeps a full counter wrap with all channels enabled and clears each flag as soon as it appears. It counts the set events per channel and records the counter value at each channel's first set. A design that tapped the wrong bit, or fired on both tap edges, would report the wrong count or the wrong first value. A design whose edge detector ignored counter writes would miss the events that loading 0x3C00 creates. Three further sequences each use tight timing: a clear write lands in the same cycle as a tap event (a design that let the clear win would drop that event), a blind write of 0 is made without a prior read (a design without read arming would erase flags), and an enable is dropped while a flag is set (a design that wiped the flag would lose the pending event).

// File: rtl/itv_pkg.sv
package itv_pkg;
  localparam int DEF_CNT_W   = 16;
  localparam int DEF_NUM_TAP = 4;
  localparam int DEF_TAP_LSB = 10;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // counter bit watched by interval channel n
  function automatic int tap_bit(input int lsb, input int n);
    return lsb + n;
  endfunction

  // counter value at which channel n first sees its tap rise
  function automatic longint first_hit(input int lsb, input int n);
    return longint'(1) << (lsb + n);
  endfunction

  // ticks between two set events of channel n
  function automatic longint interval(input int lsb, input int n);
    return longint'(1) << (lsb + n + 1);
  endfunction
endpackage

// File: rtl/itv_counter.sv
module itv_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= advance(cnt_q);
  end

  assign cnt = cnt_q;

  p_count_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/itv_tap_edge.sv
module itv_tap_edge #(
  parameter int NUM_TAP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_TAP-1:0] tap,
  output logic [NUM_TAP-1:0] rise
);
  logic [NUM_TAP-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= tap;
  end

  for (genvar g = 0; g < NUM_TAP; g++) begin : g_tap
    assign rise[g] = tap[g] & ~prev_q[g];

    p_rise_only_r4: assert property (@(posedge clk) disable iff (rst)
      rise[g] |-> (tap[g] && !$past(tap[g])));
  end
endmodule

// File: rtl/itv_flag_bank.sv
module itv_flag_bank #(
  parameter int NUM_TAP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_TAP-1:0] rise,
  input  logic [NUM_TAP-1:0] en,
  input  logic               rd_stat,
  input  logic               wr_stat,
  input  logic [NUM_TAP-1:0] wdata,
  output logic [NUM_TAP-1:0] flags
);
  logic [NUM_TAP-1:0] flags_q;
  logic [NUM_TAP-1:0] arm_q;
  logic [NUM_TAP-1:0] set_hit;
  logic [NUM_TAP-1:0] clr_hit;

  function automatic logic [NUM_TAP-1:0] next_flags(
    input logic [NUM_TAP-1:0] cur,
    input logic [NUM_TAP-1:0] clr,
    input logic [NUM_TAP-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  assign set_hit = rise & en;
  assign clr_hit = {NUM_TAP{wr_stat}} & ~wdata & arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      arm_q   <= '0;
    end else begin
      flags_q <= next_flags(flags_q, clr_hit, set_hit);
      if (wr_stat)      arm_q <= '0;
      else if (rd_stat) arm_q <= arm_q | flags_q;
    end
  end

  assign flags = flags_q;

  for (genvar g = 0; g < NUM_TAP; g++) begin : g_chk
    p_set_r4: assert property (@(posedge clk) disable iff (rst)
      (rise[g] && en[g]) |=> flags_q[g]);
    p_gated_r5: assert property (@(posedge clk) disable iff (rst)
      (rise[g] && !en[g] && !flags_q[g]) |=> !flags_q[g]);
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (flags_q[g] && !wr_stat) |=> flags_q[g]);
    p_clear_armed_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(flags_q[g]) |-> $past(wr_stat && !wdata[g] && arm_q[g]));
    p_edge_wins_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_stat && rise[g] && en[g]) |=> flags_q[g]);
  end
endmodule

// File: rtl/itv_tap_irq.sv
module itv_tap_irq
  import itv_pkg::*;
#(
  parameter int CNT_W   = DEF_CNT_W,
  parameter int NUM_TAP = DEF_NUM_TAP,
  parameter int TAP_LSB = DEF_TAP_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [1:0]         reg_sel,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  output logic [NUM_TAP-1:0] irq
);
  localparam int PAD_W = CNT_W - NUM_TAP;

  reg_sel_e           sel;
  logic               wr_cnt, wr_en, wr_stat, rd_stat;
  logic [CNT_W-1:0]   cnt;
  logic [NUM_TAP-1:0] tap;
  logic [NUM_TAP-1:0] rise;
  logic [NUM_TAP-1:0] en_q;
  logic [NUM_TAP-1:0] flags;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr_cnt  = reg_wr && (sel == SEL_CNT);
  assign wr_en   = reg_wr && (sel == SEL_EN);
  assign wr_stat = reg_wr && (sel == SEL_STAT);
  assign rd_stat = reg_rd && (sel == SEL_STAT);

  itv_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (wr_cnt),
    .load_val (reg_wdata),
    .cnt      (cnt)
  );

  for (genvar g = 0; g < NUM_TAP; g++) begin : g_taps
    assign tap[g] = cnt[tap_bit(TAP_LSB, g)];
  end

  itv_tap_edge #(.NUM_TAP(NUM_TAP)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .tap  (tap),
    .rise (rise)
  );

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= reg_wdata[NUM_TAP-1:0];
  end

  itv_flag_bank #(.NUM_TAP(NUM_TAP)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .rise    (rise),
    .en      (en_q),
    .rd_stat (rd_stat),
    .wr_stat (wr_stat),
    .wdata   (reg_wdata[NUM_TAP-1:0]),
    .flags   (flags)
  );

  assign irq = flags & en_q;

  always_comb begin
    unique case (sel)
      SEL_CNT:  reg_rdata = cnt;
      SEL_EN:   reg_rdata = {{PAD_W{1'b0}}, en_q};
      SEL_STAT: reg_rdata = {{PAD_W{1'b0}}, flags};
      default:  reg_rdata = '0;
    endcase
  end

  p_en_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_q == '0 && irq == '0));
  p_en_write_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> en_q == $past(en_q));
endmodule

// File: tb/test_itv_tap_irq.sv
module test_itv_tap_irq;
  import itv_pkg::*;
  localparam int W = 16;
  localparam int N = 4;
  localparam int L = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic [1:0]   sel = 2'd0;
  logic         wr = 1'b0;
  logic         rd = 1'b0;
  logic [W-1:0] wdata = '0;
  wire  [W-1:0] rdata;
  wire  [N-1:0] irq;

  always #4 clk = ~clk;

  itv_tap_irq #(.CNT_W(W), .NUM_TAP(N), .TAP_LSB(L)) i_itv_tap_irq (
    .clk(clk), .rst(rst), .tick(tick), .reg_sel(sel), .reg_wr(wr),
    .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // expected state, derived from the requirements
  int unsigned m_cnt = 0, m_prev = 0;
  bit [N-1:0]  m_en = '0, m_flag = '0, m_arm = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit tapv(input int unsigned v, input int n);
    return bit'((v >> (L + n)) & 1);
  endfunction

  // one clock: drive, check read data, advance the expected state, check irq
  task automatic step(input bit t, input logic [1:0] s, input bit w, input bit r,
                      input logic [W-1:0] d);
    bit [N-1:0] rise, clr, nflag, narm, nen;
    logic [W-1:0] exp_rd;
    tick = t; sel = s; wr = w; rd = r; wdata = d;
    case (s)
      2'd0: exp_rd = W'(m_cnt);
      2'd1: exp_rd = W'(m_en);
      2'd2: exp_rd = W'(m_flag);
      default: exp_rd = '0;
    endcase
    #1;
    chk("R11 read data", 32'(rdata), 32'(exp_rd));
    for (int n = 0; n < N; n++) rise[n] = tapv(m_cnt, n) && !tapv(m_prev, n);
    clr   = (w && s == 2'd2) ? (~d[N-1:0] & m_arm) : '0;
    nflag = (m_flag & ~clr) | (rise & m_en);
    narm  = (w && s == 2'd2) ? '0 : ((r && s == 2'd2) ? (m_arm | m_flag) : m_arm);
    nen   = (w && s == 2'd1) ? d[N-1:0] : m_en;
    m_prev = m_cnt;
    m_cnt  = (w && s == 2'd0) ? int'(d) : ((m_cnt + (t ? 1 : 0)) & 32'hFFFF);
    m_flag = nflag; m_arm = narm; m_en = nen;
    @(posedge clk);
    @(negedge clk);
    chk("R9 irq", 32'(irq), 32'(m_flag & m_en));
  endtask

  task automatic idle(input bit t);
    step(t, 2'd0, 1'b0, 1'b0, '0);
  endtask

  task automatic peek(input logic [1:0] s, input logic [31:0] exp, input string req);
    tick = 0; sel = s; wr = 0; rd = 0;
    #1;
    chk(req, 32'(rdata), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt_rise[N];
    int first_at[N];
    bit [N-1:0] last_irq;
    int phase;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq after reset", 32'(irq), 32'h0);
    peek(2'd0, 32'h0, "R1 counter after reset");
    peek(2'd1, 32'h0, "R1 enable after reset");
    peek(2'd2, 32'h0, "R1 status after reset");

    // R2: hold without tick, count with tick, wrap
    for (int i = 0; i < 5; i++) idle(1'b0);
    peek(2'd0, 32'h0, "R2 hold without tick");
    for (int i = 0; i < 100; i++) idle(1'b1);
    peek(2'd0, 32'd100, "R2 count with tick");
    step(1'b1, 2'd0, 1'b1, 1'b0, 16'hFFFF);   // write wins over tick
    peek(2'd0, 32'hFFFF, "R2 load priority");
    idle(1'b1);
    peek(2'd0, 32'h0, "R2 wrap to zero");

    // R5: enables off, tap 0 crosses
    step(1'b0, 2'd0, 1'b1, 1'b0, 16'd1020);
    for (int i = 0; i < 10; i++) idle(1'b1);
    peek(2'd2, 32'h0, "R5 disabled edge ignored");

    // R11: select 3 write ignored and reads 0
    step(1'b0, 2'd3, 1'b1, 1'b0, 16'hFFFF);
    peek(2'd3, 32'h0, "R11 unused select reads 0");
    peek(2'd1, 32'h0, "R11 enable untouched by select 3");
    peek(2'd0, 32'd1030, "R11 counter untouched by select 3");

    // R10/R3: full-wrap sweep, all enabled, clear each flag as it appears
    step(1'b0, 2'd1, 1'b1, 1'b0, 16'h000F);
    step(1'b0, 2'd0, 1'b1, 1'b0, 16'h0000);
    idle(1'b0);
    for (int n = 0; n < N; n++) begin cnt_rise[n] = 0; first_at[n] = -1; end
    last_irq = irq;
    phase = 0;
    for (int i = 0; i < 65536; i++) begin
      if (phase == 1)      begin step(1'b1, 2'd2, 1'b0, 1'b1, '0); phase = 2; end
      else if (phase == 2) begin step(1'b1, 2'd2, 1'b1, 1'b0, '0); phase = 0; end
      else                 idle(1'b1);
      for (int n = 0; n < N; n++) begin
        if (irq[n] && !last_irq[n]) begin
          cnt_rise[n]++;
          if (first_at[n] < 0) first_at[n] = int'(m_cnt);
        end
      end
      last_irq = irq;
      if (phase == 0 && irq != '0) phase = 1;
    end
    for (int n = 0; n < N; n++) begin
      chk($sformatf("R10 set count ch%0d", n), 32'(cnt_rise[n]), 32'(65536 / interval(L, n)));
      chk($sformatf("R3 first set ch%0d", n), 32'(first_at[n]), 32'(first_hit(L, n) + 1));
    end
    peek(2'd0, 32'(m_cnt), "R2 counter after full wrap");

    // R4: software write raises all taps at once
    step(1'b0, 2'd2, 1'b0, 1'b1, '0);
    step(1'b0, 2'd2, 1'b1, 1'b0, '0);
    step(1'b0, 2'd0, 1'b1, 1'b0, 16'h0000);
    idle(1'b0);
    step(1'b0, 2'd0, 1'b1, 1'b0, 16'h3C00);
    idle(1'b0);
    peek(2'd2, 32'hF, "R4 counter write makes edges");
    for (int i = 0; i < 4; i++) idle(1'b0);
    peek(2'd2, 32'hF, "R6 flags sticky on steady taps");

    // R7: blind write of 0 does nothing; write 1 does nothing; armed 0 clears
    step(1'b0, 2'd2, 1'b1, 1'b0, 16'h0000);
    peek(2'd2, 32'hF, "R7 clear without read ignored");
    step(1'b0, 2'd2, 1'b0, 1'b1, '0);
    step(1'b0, 2'd2, 1'b1, 1'b0, 16'h000F);
    peek(2'd2, 32'hF, "R7 writing ones ignored");
    step(1'b0, 2'd2, 1'b0, 1'b1, '0);
    step(1'b0, 2'd2, 1'b1, 1'b0, 16'h000A);
    peek(2'd2, 32'hA, "R7 armed zero bits cleared");

    // R8: clear and edge on channel 0 in the same cycle; R4 falling edges ignored
    step(1'b0, 2'd0, 1'b1, 1'b0, 16'h03FF);
    idle(1'b0);
    peek(2'd2, 32'hA, "R4 falling taps ignored");
    step(1'b0, 2'd0, 1'b1, 1'b0, 16'h0400);
    idle(1'b0);
    peek(2'd2, 32'hB, "R4 channel 0 set by write");
    step(1'b0, 2'd0, 1'b1, 1'b0, 16'h03FF);
    step(1'b1, 2'd2, 1'b0, 1'b1, '0);         // arm; counter reaches 0x400
    step(1'b0, 2'd2, 1'b1, 1'b0, 16'h0000);   // clear lands with the edge
    peek(2'd2, 32'h1, "R8 edge beats clear");

    // R9: enable removal hides request, flag kept
    step(1'b0, 2'd1, 1'b1, 1'b0, 16'h0000);
    chk("R9 irq hidden", 32'(irq), 32'h0);
    peek(2'd2, 32'h1, "R9 flag kept when disabled");
    step(1'b0, 2'd1, 1'b1, 1'b0, 16'h000F);
    chk("R9 irq restored", 32'(irq), 32'h1);

    // R4: steady high tap gives no new event after clear
    step(1'b0, 2'd2, 1'b0, 1'b1, '0);
    step(1'b0, 2'd2, 1'b1, 1'b0, 16'h0000);
    for (int i = 0; i < 5; i++) idle(1'b0);
    peek(2'd2, 32'h0, "R4 steady tap no event");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule